// File: doc/BRIEF.md
# Bidirectional Mailbox Register Pair

This block gives two synchronous ports, each running on its own clock, a way to pass single 36-bit words to each other without going through the FIFO queue. The forward register carries a word from port A to port B. The reverse register carries a word from port B to port A. Each port has the following inputs:

- a select,
- a direction (write or read),
- an enable,
- a mailbox-select,
- a data input.

Each port also receives the FIFO output word, which the block routes to that port's read bus when mailbox-select is low.

Each register has an active-low flag on its writer's side. The flag reads 1 when the register is empty and 0 while it holds unread mail. A write to a full register is refused. A read by the far port releases the register. The release reaches the writer's flag through a two-flop synchronizer, so the flag is set in one clock domain and cleared in the other.

Inside, the handshake is a pair of toggle bits for each direction, one bit in each domain. Each toggle bit is synchronized into the opposite domain. A read leaves the register contents as they were.

Top module: `mbx_pair`

## Requirements
- R1: On a rising clkA edge with aSel=1, aWr=1, aEn=1, aMbx=1 and aMailEmptyN=1, the forward register loads aDin. Port B then returns that word when it reads with bMbx=1.
- R2: On a rising clkB edge with bSel=1, bWr=1, bEn=1, bMbx=1 and bMailEmptyN=1, the reverse register loads bDin. Port A then returns that word when it reads with aMbx=1.
- R3: An accepted write drives the writer's flag (aMailEmptyN for the forward register, bMailEmptyN for the reverse register) to 0 immediately after the writing edge.
- R4: A mailbox write attempted while the writer's flag is 0 has no effect. The register keeps its earlier word, and the flag stays 0.
- R5: A port's read bus is active when that port has Sel=1 and Wr=0, and OutEn is then 1. The bus carries the mailbox word when Mbx=1 and the port's FIfoQ input when Mbx=0. When the read bus is not active, OutEn=0 and Dout is all zeros.
- R6: A mailbox read (Sel=1, Wr=0, En=1, Mbx=1) by the reader sets the writer's flag back to 1. The read must come at least two reader clocks after the write. The flag is still 0 right after the read edge, and it is 1 after the second writer clock edge that follows the read.
- R7: Reading a mailbox register leaves its contents unchanged. A second read returns the same word.
- R8: A mailbox read while the register holds no unread mail returns the retained word and leaves the writer's flag at 1.
- R9: Reset (rstN=0) clears both registers to zero and drives both flags to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| aSel | input | 1 | Port A select, active high |
| aWr | input | 1 | Port A direction: 1 write, 0 read |
| aEn | input | 1 | Port A transfer enable |
| aMbx | input | 1 | Port A mailbox select: 1 mailbox, 0 FIFO |
| aDin | input | 36 | Port A write data |
| aFifoQ | input | 36 | FIFO output word for port A |
| aDout | output | 36 | Port A read bus |
| aOutEn | output | 1 | Port A read bus active |
| aMailEmptyN | output | 1 | Forward register flag, 0 = mail present (clkA domain) |
| bSel | input | 1 | Port B select, active high |
| bWr | input | 1 | Port B direction: 1 write, 0 read |
| bEn | input | 1 | Port B transfer enable |
| bMbx | input | 1 | Port B mailbox select: 1 mailbox, 0 FIFO |
| bDin | input | 36 | Port B write data |
| bFifoQ | input | 36 | FIFO output word for port B |
| bDout | output | 36 | Port B read bus |
| bOutEn | output | 1 | Port B read bus active |
| bMailEmptyN | output | 1 | Reverse register flag, 0 = mail present (clkB domain) |

## Verification
A toggle bit that gets out of step shows up as a flag stuck at 0 or as a flag that rises early. A stuck flag locks out every later write, and the next word sent returns the earlier data. An early rise shows as a flag already 1 right after the read edge, when two writer clocks should still be pending. A register that takes a write while full, or that changes when read, returns the wrong word on the reader's first or second read. A wrong select on the output mux shows at once on the read bus within the same cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_DATA_W = 36;
  localparam int MBX_SYNC_STAGES = 2;

  typedef struct packed {
    logic loadFwd;
    logic loadRev;
  } mbxStrobes_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= 1'b0;
        else       chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= 1'b0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic wrClk,
  input  logic rdClk,
  input  logic rstN,
  input  logic wrSel,
  input  logic wrDir,
  input  logic wrEn,
  input  logic wrMbx,
  input  logic rdSel,
  input  logic rdDir,
  input  logic rdEn,
  input  logic rdMbx,
  output logic load,
  output logic mailEmptyN
);
  logic wrReq, rdReq;
  logic wrTog, rdTog;
  logic rdTogAtWr, wrTogAtRd;
  logic pending, ack;

  assign wrReq = wrSel & wrDir & wrEn & wrMbx;
  assign rdReq = rdSel & ~rdDir & rdEn & rdMbx;

  // writer domain: the toggle flips on each accepted write
  mbx_sync #(.STAGES(SYNC_STAGES)) u_syncToWr (
    .clk(wrClk), .rstN(rstN), .d(rdTog), .q(rdTogAtWr)
  );

  assign mailEmptyN = (wrTog == rdTogAtWr);
  assign load       = wrReq & mailEmptyN;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)     wrTog <= 1'b0;
    else if (load) wrTog <= ~wrTog;
  end

  // reader domain: the toggle flips when pending mail is read
  mbx_sync #(.STAGES(SYNC_STAGES)) u_syncToRd (
    .clk(rdClk), .rstN(rstN), .d(wrTog), .q(wrTogAtRd)
  );

  assign pending = (wrTogAtRd != rdTog);
  assign ack     = rdReq & pending;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)    rdTog <= 1'b0;
    else if (ack) rdTog <= ~rdTog;
  end

  AST_FLAG_DROPS_ON_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrReq && mailEmptyN) |=> !mailEmptyN); // R3
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    !mailEmptyN |=> $stable(wrTog)); // R4
  AST_ACK_NEEDS_PENDING: assert property (@(posedge rdClk) disable iff (!rstN)
    !pending |=> $stable(rdTog)); // R8
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  mbxStrobes_t       strb,
  input  logic              aSel,
  input  logic              aWr,
  input  logic              aMbx,
  input  logic [DATA_W-1:0] aDin,
  input  logic [DATA_W-1:0] aFifoQ,
  input  logic              bSel,
  input  logic              bWr,
  input  logic              bMbx,
  input  logic [DATA_W-1:0] bDin,
  input  logic [DATA_W-1:0] bFifoQ,
  output logic [DATA_W-1:0] aDout,
  output logic              aOutEn,
  output logic [DATA_W-1:0] bDout,
  output logic              bOutEn
);
  logic [DATA_W-1:0] fwdReg, revReg;

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)             fwdReg <= '0;
    else if (strb.loadFwd) fwdReg <= aDin;
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN)             revReg <= '0;
    else if (strb.loadRev) revReg <= bDin;
  end

  function automatic logic [DATA_W-1:0] pickBus(
    input logic active, input logic mbx,
    input logic [DATA_W-1:0] mail, input logic [DATA_W-1:0] fifo);
    if (!active)  return '0;
    else if (mbx) return mail;
    else          return fifo;
  endfunction

  always_comb begin
    aOutEn = aSel & ~aWr;
    bOutEn = bSel & ~bWr;
    aDout  = pickBus(aOutEn, aMbx, revReg, aFifoQ);
    bDout  = pickBus(bOutEn, bMbx, fwdReg, bFifoQ);
  end

  AST_FWD_HOLD: assert property (@(posedge clkA) disable iff (!rstN)
    !strb.loadFwd |=> $stable(fwdReg)); // R7
  AST_REV_HOLD: assert property (@(posedge clkB) disable iff (!rstN)
    !strb.loadRev |=> $stable(revReg)); // R7
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int DATA_W      = MBX_DATA_W,
  parameter int SYNC_STAGES = MBX_SYNC_STAGES
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              aSel,
  input  logic              aWr,
  input  logic              aEn,
  input  logic              aMbx,
  input  logic [DATA_W-1:0] aDin,
  input  logic [DATA_W-1:0] aFifoQ,
  output logic [DATA_W-1:0] aDout,
  output logic              aOutEn,
  output logic              aMailEmptyN,
  input  logic              bSel,
  input  logic              bWr,
  input  logic              bEn,
  input  logic              bMbx,
  input  logic [DATA_W-1:0] bDin,
  input  logic [DATA_W-1:0] bFifoQ,
  output logic [DATA_W-1:0] bDout,
  output logic              bOutEn,
  output logic              bMailEmptyN
);
  mbxStrobes_t strb;
  logic loadFwd, loadRev;

  // forward direction: written on port A, read on port B
  mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrlFwd (
    .wrClk(clkA), .rdClk(clkB), .rstN(rstN),
    .wrSel(aSel), .wrDir(aWr), .wrEn(aEn), .wrMbx(aMbx),
    .rdSel(bSel), .rdDir(bWr), .rdEn(bEn), .rdMbx(bMbx),
    .load(loadFwd), .mailEmptyN(aMailEmptyN)
  );

  // reverse direction: written on port B, read on port A
  mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrlRev (
    .wrClk(clkB), .rdClk(clkA), .rstN(rstN),
    .wrSel(bSel), .wrDir(bWr), .wrEn(bEn), .wrMbx(bMbx),
    .rdSel(aSel), .rdDir(aWr), .rdEn(aEn), .rdMbx(aMbx),
    .load(loadRev), .mailEmptyN(bMailEmptyN)
  );

  assign strb.loadFwd = loadFwd;
  assign strb.loadRev = loadRev;

  mbx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .strb(strb),
    .aSel(aSel), .aWr(aWr), .aMbx(aMbx), .aDin(aDin), .aFifoQ(aFifoQ),
    .bSel(bSel), .bWr(bWr), .bMbx(bMbx), .bDin(bDin), .bFifoQ(bFifoQ),
    .aDout(aDout), .aOutEn(aOutEn), .bDout(bDout), .bOutEn(bOutEn)
  );

  AST_RESET_EMPTY: assert property (@(posedge clkA)
    $rose(rstN) |-> (aMailEmptyN && bMailEmptyN)); // R9
endmodule

// File: tb/mbx_pair_tb.sv
module mbx_pair_tb_top;
  localparam int W = 36;
  localparam logic [W-1:0] FIFO_A = 36'hF1F0A_A5A5;
  localparam logic [W-1:0] FIFO_B = 36'hF1F0B_5A5A;
  // bit 36: 0 = port A writes and port B reads, 1 = port B writes and port A reads
  localparam logic [W:0] VEC_TBL [0:5] = '{
    {1'b0, 36'h1_2345_6789}, {1'b1, 36'hA_BCDE_F012},
    {1'b0, 36'hF_FFFF_FFFF}, {1'b1, 36'h0_0000_0001},
    {1'b1, 36'h8_0000_0000}, {1'b0, 36'h5_5555_AAAA}
  };

  logic clkA = 0, clkB = 0, rstN = 0;
  logic aSel = 0, aWr = 0, aEn = 0, aMbx = 0;
  logic bSel = 0, bWr = 0, bEn = 0, bMbx = 0;
  logic [W-1:0] aDin = '0, bDin = '0;
  logic [W-1:0] aFifoQ = FIFO_A, bFifoQ = FIFO_B;
  logic [W-1:0] aDout, bDout;
  logic aOutEn, bOutEn, aMailEmptyN, bMailEmptyN;
  int checks = 0, errors = 0;
  logic [W-1:0] got;

  always #10 clkA = ~clkA;
  always #7  clkB = ~clkB;

  mbx_pair dut_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .aSel(aSel), .aWr(aWr), .aEn(aEn), .aMbx(aMbx), .aDin(aDin), .aFifoQ(aFifoQ),
    .aDout(aDout), .aOutEn(aOutEn), .aMailEmptyN(aMailEmptyN),
    .bSel(bSel), .bWr(bWr), .bEn(bEn), .bMbx(bMbx), .bDin(bDin), .bFifoQ(bFifoQ),
    .bDout(bDout), .bOutEn(bOutEn), .bMailEmptyN(bMailEmptyN)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeA(input logic [W-1:0] d);
    @(negedge clkA); aSel = 1; aWr = 1; aEn = 1; aMbx = 1; aDin = d;
    @(negedge clkA); aSel = 0; aWr = 0; aEn = 0; aMbx = 0;
  endtask

  task automatic writeB(input logic [W-1:0] d);
    @(negedge clkB); bSel = 1; bWr = 1; bEn = 1; bMbx = 1; bDin = d;
    @(negedge clkB); bSel = 0; bWr = 0; bEn = 0; bMbx = 0;
  endtask

  task automatic readA(input logic mbx, output logic [W-1:0] d);
    @(negedge clkA); aSel = 1; aWr = 0; aEn = 1; aMbx = mbx;
    #1 d = aDout;
    @(negedge clkA); aSel = 0; aEn = 0; aMbx = 0;
  endtask

  task automatic readB(input logic mbx, output logic [W-1:0] d);
    @(negedge clkB); bSel = 1; bWr = 0; bEn = 1; bMbx = mbx;
    #1 d = bDout;
    @(negedge clkB); bSel = 0; bEn = 0; bMbx = 0;
  endtask

  task automatic waitA(input int n);
    repeat (n) @(posedge clkA);
    #1;
  endtask

  task automatic waitB(input int n);
    repeat (n) @(posedge clkB);
    #1;
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitA(3);
    @(negedge clkA); rstN = 1;
    // R9: reset state
    chk("R9 forward flag after reset", W'(aMailEmptyN), W'(1));
    chk("R9 reverse flag after reset", W'(bMailEmptyN), W'(1));
    readB(1'b1, got); chk("R9 forward register zero", got, '0);
    readA(1'b1, got); chk("R9 reverse register zero", got, '0);
    // R8: reads of an empty mailbox leave the flags at 1
    waitA(3);
    chk("R8 forward flag after empty read", W'(aMailEmptyN), W'(1));
    chk("R8 reverse flag after empty read", W'(bMailEmptyN), W'(1));

    // table walk: R1, R2, R3, R6
    foreach (VEC_TBL[i]) begin
      if (!VEC_TBL[i][W]) begin
        writeA(VEC_TBL[i][W-1:0]);
        chk("R3 forward flag low after write", W'(aMailEmptyN), W'(0));
        waitB(3);
        readB(1'b1, got); chk("R1 port B reads forward word", got, VEC_TBL[i][W-1:0]);
        chk("R6 forward flag still low after read edge", W'(aMailEmptyN), W'(0));
        waitA(3);
        chk("R6 forward flag high after sync", W'(aMailEmptyN), W'(1));
      end else begin
        writeB(VEC_TBL[i][W-1:0]);
        chk("R3 reverse flag low after write", W'(bMailEmptyN), W'(0));
        waitA(3);
        readA(1'b1, got); chk("R2 port A reads reverse word", got, VEC_TBL[i][W-1:0]);
        chk("R6 reverse flag still low after read edge", W'(bMailEmptyN), W'(0));
        waitB(3);
        chk("R6 reverse flag high after sync", W'(bMailEmptyN), W'(1));
      end
    end

    // R4: a write into a full register is refused
    writeA(36'h1_1111_1111);
    writeA(36'h2_2222_2222);
    chk("R4 forward flag stays low", W'(aMailEmptyN), W'(0));
    waitB(3);
    readB(1'b1, got); chk("R4 first word kept", got, 36'h1_1111_1111);
    waitA(3);
    // R7: a second read returns the same word; R8: the flag stays at 1
    readB(1'b1, got); chk("R7 forward word retained after read", got, 36'h1_1111_1111);
    waitA(3);
    chk("R8 forward flag unchanged by extra read", W'(aMailEmptyN), W'(1));

    writeB(36'h3_3333_3333);
    writeB(36'h4_4444_4444);
    chk("R4 reverse flag stays low", W'(bMailEmptyN), W'(0));
    waitA(3);
    readA(1'b1, got); chk("R4 reverse first word kept", got, 36'h3_3333_3333);
    waitB(3);
    readA(1'b1, got); chk("R7 reverse word retained after read", got, 36'h3_3333_3333);

    // R5: output mux and idle bus
    readA(1'b0, got); chk("R5 port A FIFO select", got, FIFO_A);
    readB(1'b0, got); chk("R5 port B FIFO select", got, FIFO_B);
    @(negedge clkA); aSel = 1; aWr = 0; #1;
    chk("R5 port A bus active on read", W'(aOutEn), W'(1));
    aSel = 0; #1;
    chk("R5 port A idle bus zero", aDout, '0);
    chk("R5 port A OutEn low when idle", W'(aOutEn), W'(0));
    @(negedge clkB); bSel = 1; bWr = 1; bMbx = 1; #1;
    chk("R5 port B bus zero in write direction", bDout, '0);
    bSel = 0; bWr = 0; bMbx = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule